// File: doc/BRIEF.md
# SPI Slave with Semaphore-Guarded Buffers

This block is a serial-peripheral slave that moves bytes between a four-wire SPI line and two small internal buffers: a transmit buffer and a receive buffer. A single ownership bit decides who may use the buffers. When the serial side owns them, a transaction shifts transmit bytes out and stores received bytes. When the processor side owns them, it can refill the transmit buffer and read results. Any transaction that begins while the processor holds ownership is ignored entirely.

The processor side uses single-cycle request strobes. One strobe takes ownership and another hands it back. Two latched event flags, one for transaction end and one for ownership granted, each have their own clear strobe. An optional link turns every completed transaction into an automatic ownership request. Two configuration bytes are also provided. The idle byte is sent whenever the slave is not serving data. The overflow byte is sent once the master clocks past the programmed transmit length. Two counters report how many bytes the last accepted transaction actually took from the transmit buffer and stored into the receive buffer.

The serial inputs pass through a short synchronizer into the system clock domain. Every serial event is therefore handled on the system clock, which must run several times faster than SCK.

Top module: `spis_sem_slave`

## Requirements
- R1: After reset the processor owns the buffers (`sem_cpu`=1), both event flags are 0, both byte counters are 0, `spi_miso` is 0 and both buffers hold zeros.
- R2: When CSN rises at the end of an accepted transaction, `evt_end` becomes 1 and stays 1 until a `clr_end_evt` pulse. `clr_end_evt` does not change `evt_acquired`.
- R3: A `req_acquire` pulse while CSN is high gives ownership to the processor at the same clock edge that samples it, and sets `evt_acquired`. `evt_acquired` stays set until a `clr_acq_evt` pulse.
- R4: A `req_acquire` that arrives while CSN is low is held pending. The slave keeps ownership until CSN has risen, and then the pending request is granted.
- R5: With `end_acq_link`=1, the end of an accepted transaction gives ownership to the processor and sets `evt_acquired` without any `req_acquire` pulse. With `end_acq_link`=0, the slave keeps ownership.
- R6: A `req_release` pulse while the processor owns the buffers returns them to the slave. A `req_release` pulse while the slave already owns them changes neither ownership nor any flag.
- R7: A transaction whose CSN falling edge finds the processor owning the buffers is ignored. MISO carries `def_char` for every byte, no receive entry is written, `evt_end` stays 0, and both counters keep their previous values. This holds even if ownership is released while CSN is still low.
- R8: SPI mode 0 is used. MOSI is sampled on the SCK rising edge and MISO changes after the SCK falling edge, most significant bit first. The first bit is valid once CSN has fallen. MISO is 0 while CSN is high.
- R9: In an accepted transaction, byte k on MISO is transmit buffer entry k for k < `tx_len`, and `orc_char` for every later byte. `tx_amount` reports min(bytes clocked, `tx_len`).
- R10: In an accepted transaction, received byte k is written to receive entry k for k < `rx_len`, and later bytes are discarded. `rx_amount` reports min(bytes clocked, `rx_len`). Lengths above DEPTH act as DEPTH.
- R11: Writes on the transmit-buffer port are accepted only while the processor owns the buffers. Other writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_csn | input | 1 | Active-low chip select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| req_acquire | input | 1 | Processor ownership request strobe |
| req_release | input | 1 | Processor ownership return strobe |
| clr_end_evt | input | 1 | Clears the end-of-transaction flag |
| clr_acq_evt | input | 1 | Clears the ownership-granted flag |
| end_acq_link | input | 1 | Enables automatic acquire after each accepted end |
| def_char | input | 8 | Byte sent while the slave is not serving data |
| orc_char | input | 8 | Byte sent past the transmit length |
| tx_len | input | $clog2(DEPTH+1) | Transmit byte budget |
| rx_len | input | $clog2(DEPTH+1) | Receive byte budget |
| tx_wr_en | input | 1 | Transmit buffer write strobe |
| tx_wr_addr | input | $clog2(DEPTH) | Transmit buffer write index |
| tx_wr_data | input | 8 | Transmit buffer write data |
| rx_rd_addr | input | $clog2(DEPTH) | Receive buffer read index |
| rx_rd_data | output | 8 | Receive buffer read data (combinational) |
| evt_end | output | 1 | Latched end-of-transaction flag |
| evt_acquired | output | 1 | Latched ownership-granted flag |
| sem_cpu | output | 1 | 1 while the processor owns the buffers |
| tx_amount | output | $clog2(DEPTH+1) | Bytes sent from the buffer in the last accepted transaction |
| rx_amount | output | $clog2(DEPTH+1) | Bytes stored in the last accepted transaction |

## Verification
The bench uses the defaults DEPTH=8 and SYNC_STAGES=2, so length registers are four bits wide. With these values a full-buffer transfer (length equal to DEPTH) can be run, as well as transfers past both lengths and zero-length and zero-byte frames. A half SCK period of six system clocks leaves the two-stage synchronizer and the output register enough margin for exact MISO sampling at each master rising edge. Under these settings the deferred acquire, the ignored frame and the dropped buffer write can all be seen cycle by cycle.

// File: rtl/spis_pkg.sv
package spis_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        OWN_SLAVE = 1'b0,
        OWN_CPU   = 1'b1
    } owner_e;

    // synchronized line state and edges, all in the system clock domain
    typedef struct packed {
        logic csn_hi;
        logic csn_fall;
        logic csn_rise;
        logic sck_rise;
        logic sck_fall;
        logic mosi;
    } line_evt_t;

    // byte to present on MISO for the current slot
    function automatic logic [BYTE_W-1:0] pick_char(
        input logic              serving,
        input logic              in_budget,
        input logic [BYTE_W-1:0] buf_byte,
        input logic [BYTE_W-1:0] idle_byte,
        input logic [BYTE_W-1:0] over_byte
    );
        if (!serving)
            return idle_byte;
        else if (in_budget)
            return buf_byte;
        else
            return over_byte;
    endfunction

endpackage

// File: rtl/spis_line_sync.sv
module spis_line_sync
    import spis_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sck_pin,
    input  logic      csn_pin,
    input  logic      mosi_pin,
    output line_evt_t ev
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sck_sr, csn_sr, mosi_sr;
    logic sck_prev, csn_prev;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_sr[g]  <= 1'b0;
                    csn_sr[g]  <= 1'b1;
                    mosi_sr[g] <= 1'b0;
                end else if (g == 0) begin
                    sck_sr[g]  <= sck_pin;
                    csn_sr[g]  <= csn_pin;
                    mosi_sr[g] <= mosi_pin;
                end else begin
                    sck_sr[g]  <= sck_sr[(g == 0) ? 0 : g-1];
                    csn_sr[g]  <= csn_sr[(g == 0) ? 0 : g-1];
                    mosi_sr[g] <= mosi_sr[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b0;
            csn_prev <= 1'b1;
        end else begin
            sck_prev <= sck_sr[LAST];
            csn_prev <= csn_sr[LAST];
        end
    end

    always_comb begin
        ev.csn_hi   = csn_sr[LAST];
        ev.csn_fall = csn_prev & ~csn_sr[LAST];
        ev.csn_rise = ~csn_prev & csn_sr[LAST];
        // clock edges only count inside a selected frame
        ev.sck_rise = ~csn_sr[LAST] & ~sck_prev & sck_sr[LAST];
        ev.sck_fall = ~csn_sr[LAST] & sck_prev & ~sck_sr[LAST];
        ev.mosi     = mosi_sr[LAST];
    end

endmodule

// File: rtl/spis_sem_ctrl.sv
module spis_sem_ctrl
    import spis_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_acquire,
    input  logic req_release,
    input  logic clr_end_evt,
    input  logic clr_acq_evt,
    input  logic end_acq_link,
    input  logic end_pulse,
    input  logic csn_hi,
    output logic sem_cpu,
    output logic evt_end,
    output logic evt_acquired
);
    owner_e owner;
    logic   acq_pend;
    logic   acq_want;
    logic   grant;

    always_comb begin
        acq_want = acq_pend | req_acquire | (end_acq_link & end_pulse);
        grant    = acq_want & csn_hi;
        sem_cpu  = (owner == OWN_CPU);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner        <= OWN_CPU;
            acq_pend     <= 1'b0;
            evt_end      <= 1'b0;
            evt_acquired <= 1'b0;
        end else begin
            acq_pend <= acq_want & ~csn_hi;

            if (grant)
                owner <= OWN_CPU;
            else if (req_release)
                owner <= OWN_SLAVE;

            if (grant)
                evt_acquired <= 1'b1;
            else if (clr_acq_evt)
                evt_acquired <= 1'b0;

            if (end_pulse)
                evt_end <= 1'b1;
            else if (clr_end_evt)
                evt_end <= 1'b0;
        end
    end

    AST_HOLD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        (!csn_hi && !sem_cpu) |=> !sem_cpu); // R4

    AST_GRANT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        $rose(sem_cpu) |-> evt_acquired); // R3

    AST_LINK_TAKES: assert property (@(posedge clk) disable iff (rst)
        ($rose(evt_end) && $past(end_acq_link)) |-> sem_cpu); // R5

endmodule

// File: rtl/spis_xfer.sv
module spis_xfer
    import spis_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LW    = $clog2(DEPTH + 1),
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  line_evt_t         ev,
    input  logic              sem_cpu,
    input  logic [BYTE_W-1:0] def_char,
    input  logic [BYTE_W-1:0] orc_char,
    input  logic [LW-1:0]     tx_len,
    input  logic [LW-1:0]     rx_len,
    input  logic              tx_wr_en,
    input  logic [AW-1:0]     tx_wr_addr,
    input  logic [BYTE_W-1:0] tx_wr_data,
    input  logic [AW-1:0]     rx_rd_addr,
    output logic [BYTE_W-1:0] rx_rd_data,
    output logic              miso,
    output logic              end_pulse,
    output logic              rx_we,
    output logic [LW-1:0]     tx_amount,
    output logic [LW-1:0]     rx_amount
);
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

    logic [BYTE_W-1:0] tx_mem [DEPTH];
    logic [BYTE_W-1:0] rx_mem [DEPTH];

    logic              serving;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [LW-1:0]     tx_cnt, rx_cnt;
    logic [LW-1:0]     tx_lim, rx_lim;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] cur_byte;
    logic [BYTE_W-1:0] first_byte;

    always_comb begin
        tx_lim     = (tx_len > DEPTH_L) ? DEPTH_L : tx_len;
        rx_lim     = (rx_len > DEPTH_L) ? DEPTH_L : rx_len;
        byte_done  = ev.sck_rise && (bit_cnt == 3'd7);
        rx_byte    = {shreg[BYTE_W-2:0], ev.mosi};
        rx_we      = byte_done && serving && (rx_cnt < rx_lim);
        cur_byte   = pick_char(serving, tx_cnt < tx_lim,
                               tx_mem[tx_cnt[AW-1:0]], def_char, orc_char);
        first_byte = pick_char(!sem_cpu, tx_lim != '0,
                               tx_mem[0], def_char, orc_char);
        end_pulse  = ev.csn_rise && serving;
        rx_rd_data = rx_mem[rx_rd_addr];
    end

    // buffer storage
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                tx_mem[i] <= '0;
                rx_mem[i] <= '0;
            end
        end else begin
            if (tx_wr_en && sem_cpu)
                tx_mem[tx_wr_addr] <= tx_wr_data;
            if (rx_we)
                rx_mem[rx_cnt[AW-1:0]] <= rx_byte;
        end
    end

    // frame and bit engine
    always_ff @(posedge clk) begin
        if (rst) begin
            serving   <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            tx_cnt    <= '0;
            rx_cnt    <= '0;
            miso      <= 1'b0;
            tx_amount <= '0;
            rx_amount <= '0;
        end else if (ev.csn_fall) begin
            serving <= !sem_cpu;
            bit_cnt <= '0;
            shreg   <= '0;
            tx_cnt  <= '0;
            rx_cnt  <= '0;
            miso    <= first_byte[BYTE_W-1];
        end else if (ev.csn_rise) begin
            serving <= 1'b0;
            miso    <= 1'b0;
            if (serving) begin
                tx_amount <= tx_cnt;
                rx_amount <= rx_cnt;
            end
        end else begin
            if (ev.sck_rise) begin
                shreg   <= rx_byte;
                bit_cnt <= bit_cnt + 3'd1;
                if (rx_we)
                    rx_cnt <= rx_cnt + 1'b1;
                if (byte_done && serving && (tx_cnt < tx_lim))
                    tx_cnt <= tx_cnt + 1'b1;
            end
            if (ev.sck_fall)
                miso <= cur_byte[3'd7 - bit_cnt];
        end
    end

    AST_RX_BOUND: assert property (@(posedge clk) disable iff (rst)
        rx_we |-> (rx_cnt < DEPTH_L)); // R10

endmodule

// File: rtl/spis_sem_slave.sv
module spis_sem_slave
    import spis_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LW          = $clog2(DEPTH + 1),
    parameter int AW          = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              req_acquire,
    input  logic              req_release,
    input  logic              clr_end_evt,
    input  logic              clr_acq_evt,
    input  logic              end_acq_link,
    input  logic [BYTE_W-1:0] def_char,
    input  logic [BYTE_W-1:0] orc_char,
    input  logic [LW-1:0]     tx_len,
    input  logic [LW-1:0]     rx_len,
    input  logic              tx_wr_en,
    input  logic [AW-1:0]     tx_wr_addr,
    input  logic [BYTE_W-1:0] tx_wr_data,
    input  logic [AW-1:0]     rx_rd_addr,
    output logic [BYTE_W-1:0] rx_rd_data,
    output logic              evt_end,
    output logic              evt_acquired,
    output logic              sem_cpu,
    output logic [LW-1:0]     tx_amount,
    output logic [LW-1:0]     rx_amount
);
    line_evt_t ev;
    logic      end_pulse;
    logic      rx_we;

    spis_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sck_pin  (spi_sck),
        .csn_pin  (spi_csn),
        .mosi_pin (spi_mosi),
        .ev       (ev)
    );

    spis_sem_ctrl u_sem (
        .clk          (clk),
        .rst          (rst),
        .req_acquire  (req_acquire),
        .req_release  (req_release),
        .clr_end_evt  (clr_end_evt),
        .clr_acq_evt  (clr_acq_evt),
        .end_acq_link (end_acq_link),
        .end_pulse    (end_pulse),
        .csn_hi       (ev.csn_hi),
        .sem_cpu      (sem_cpu),
        .evt_end      (evt_end),
        .evt_acquired (evt_acquired)
    );

    spis_xfer #(.DEPTH(DEPTH), .LW(LW), .AW(AW)) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .sem_cpu    (sem_cpu),
        .def_char   (def_char),
        .orc_char   (orc_char),
        .tx_len     (tx_len),
        .rx_len     (rx_len),
        .tx_wr_en   (tx_wr_en),
        .tx_wr_addr (tx_wr_addr),
        .tx_wr_data (tx_wr_data),
        .rx_rd_addr (rx_rd_addr),
        .rx_rd_data (rx_rd_data),
        .miso       (spi_miso),
        .end_pulse  (end_pulse),
        .rx_we      (rx_we),
        .tx_amount  (tx_amount),
        .rx_amount  (rx_amount)
    );

    AST_END_FROM_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_end) |-> $past(ev.csn_rise)); // R2

    AST_NO_WRITE_WHEN_CPU: assert property (@(posedge clk) disable iff (rst)
        rx_we |-> !sem_cpu); // R7

    AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (ev.csn_hi && $past(ev.csn_hi)) |-> !spi_miso); // R8

endmodule

// File: tb/spis_sem_slave_test.sv
module spis_sem_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int LW         = $clog2(DEPTH + 1);
    localparam int AW         = $clog2(DEPTH);
    localparam int HALF       = 6;
    localparam logic [7:0] DEF = 8'h5A;
    localparam logic [7:0] ORC = 8'hC3;
    localparam int NVEC       = 6;

    // [31] release first, [30] link, [29] expect end, [27:24] bytes,
    // [23:20] tx_len, [19:16] rx_len, [15:12] expected tx_amount, [11:8] expected rx_amount
    localparam logic [31:0] VEC [NVEC] = '{
        32'hE3333300,
        32'hE5242400,
        32'h42442400,
        32'hE0330000,
        32'hA8888800,
        32'hE2000000
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic miso;
    logic req_acq = 1'b0, req_rel = 1'b0, clr_end = 1'b0, clr_acq = 1'b0, link = 1'b0;
    logic [LW-1:0] tx_len = '0, rx_len = '0;
    logic tx_we = 1'b0;
    logic [AW-1:0] tx_wa = '0, rx_ra = '0;
    logic [7:0] tx_wd = '0, rx_rd;
    logic evt_end, evt_acq, sem_cpu;
    logic [LW-1:0] tx_amt, rx_amt;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;
    logic [7:0] got [16];
    logic [7:0] sh_tx [DEPTH];
    logic [7:0] sh_rx [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    spis_sem_slave #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi), .spi_miso(miso),
        .req_acquire(req_acq), .req_release(req_rel),
        .clr_end_evt(clr_end), .clr_acq_evt(clr_acq), .end_acq_link(link),
        .def_char(DEF), .orc_char(ORC), .tx_len(tx_len), .rx_len(rx_len),
        .tx_wr_en(tx_we), .tx_wr_addr(tx_wa), .tx_wr_data(tx_wd),
        .rx_rd_addr(rx_ra), .rx_rd_data(rx_rd),
        .evt_end(evt_end), .evt_acquired(evt_acq), .sem_cpu(sem_cpu),
        .tx_amount(tx_amt), .rx_amount(rx_amt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input int v, input int i);
        return 8'hA0 ^ 8'(v * 16 + i);
    endfunction

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic wr_tx(input int a, input logic [7:0] d);
        @(negedge clk); tx_we = 1'b1; tx_wa = AW'(a); tx_wd = d;
        @(negedge clk); tx_we = 1'b0;
    endtask

    task automatic spi_frame(input int n, input int v);
        @(negedge clk); csn = 1'b0;
        for (int b = 0; b < n; b++) begin
            logic [7:0] m;
            m = mbyte(v, b);
            got[b] = '0;
            for (int k = 7; k >= 0; k--) begin
                mosi = m[k];
                repeat (HALF) @(negedge clk);
                got[b][k] = miso;
                sck = 1'b1;
                repeat (HALF) @(negedge clk);
                sck = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic check_rx(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            rx_ra = AW'(a);
            #1;
            chk(req, {24'h0, rx_rd}, {24'h0, sh_rx[a]});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            sh_tx[i] = '0;
            sh_rx[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 sem_cpu", {31'h0, sem_cpu}, 32'h1);
        chk("R1 evt_end", {31'h0, evt_end}, 32'h0);
        chk("R1 evt_acq", {31'h0, evt_acq}, 32'h0);
        chk("R1 miso", {31'h0, miso}, 32'h0);
        chk("R1 counts", {24'h0, tx_amt, rx_amt}, 32'h0);
        check_rx("R1 rx buffer");

        // vector walk
        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] w;
            logic rel, sc, ee;
            int n, txl, rxl;
            w   = VEC[v];
            rel = w[31]; sc = w[30]; ee = w[29];
            n   = int'(w[27:24]); txl = int'(w[23:20]); rxl = int'(w[19:16]);
            if (!sem_cpu) pulse(req_acq);
            for (int i = 0; i < DEPTH; i++) begin
                sh_tx[i] = 8'h30 + 8'(v * 8 + i);
                wr_tx(i, sh_tx[i]);
            end
            tx_len = LW'(txl); rx_len = LW'(rxl); link = sc;
            pulse(clr_end);
            pulse(clr_acq);
            if (rel) pulse(req_rel);
            spi_frame(n, v);
            for (int b = 0; b < n; b++) begin
                logic [7:0] e;
                e = !rel ? DEF : (b < txl) ? sh_tx[b] : ORC;
                chk(rel ? "R9 R8 miso byte" : "R7 miso default", {24'h0, got[b]}, {24'h0, e});
            end
            if (rel)
                for (int b = 0; b < n && b < rxl; b++) sh_rx[b] = mbyte(v, b);
            chk(rel ? "R2 end set" : "R7 no end", {31'h0, evt_end}, {31'h0, ee});
            chk("R9 tx_amount", {28'h0, tx_amt}, {28'h0, w[15:12]});
            chk("R10 rx_amount", {28'h0, rx_amt}, {28'h0, w[11:8]});
            check_rx(rel ? "R10 rx data" : "R7 rx untouched");
            if (ee && sc) begin
                chk("R5 link owner", {31'h0, sem_cpu}, 32'h1);
                chk("R5 link flag", {31'h0, evt_acq}, 32'h1);
            end else if (ee) begin
                chk("R5 no link owner", {31'h0, sem_cpu}, 32'h0);
            end else begin
                chk("R7 owner kept", {31'h0, sem_cpu}, 32'h1);
            end
        end

        // R6: release with processor owning, then a second release with slave owning
        pulse(req_rel);
        pulse(clr_acq);
        chk("R6 release", {31'h0, sem_cpu}, 32'h0);
        pulse(req_rel);
        chk("R6 release ignored owner", {31'h0, sem_cpu}, 32'h0);
        chk("R6 release ignored flag", {31'h0, evt_acq}, 32'h0);

        // R11: write while slave owns is dropped
        link = 1'b0;
        wr_tx(0, 8'hEE);
        tx_len = LW'(1); rx_len = '0;
        spi_frame(1, 9);
        chk("R11 dropped write", {24'h0, got[0]}, {24'h0, sh_tx[0]});
        chk("R9 tx_amount one", {28'h0, tx_amt}, 32'h1);

        // R4: acquire inside a frame waits for CSN high
        pulse(clr_end);
        @(negedge clk); csn = 1'b0;
        repeat (HALF) @(negedge clk);
        pulse(req_acq);
        repeat (10) @(negedge clk);
        chk("R4 held in frame", {31'h0, sem_cpu}, 32'h0);
        chk("R4 no flag in frame", {31'h0, evt_acq}, 32'h0);
        csn = 1'b1;
        repeat (8) @(negedge clk);
        chk("R4 granted after rise", {31'h0, sem_cpu}, 32'h1);
        chk("R4 flag after rise", {31'h0, evt_acq}, 32'h1);
        chk("R2 end empty frame", {31'h0, evt_end}, 32'h1);
        pulse(clr_end);
        chk("R2 end cleared", {31'h0, evt_end}, 32'h0);
        chk("R2 acq kept", {31'h0, evt_acq}, 32'h1);

        // R3: acquire with CSN high is granted at the sampling edge
        pulse(req_rel);
        pulse(clr_acq);
        chk("R3 flag cleared", {31'h0, evt_acq}, 32'h0);
        @(negedge clk); req_acq = 1'b1;
        @(negedge clk); req_acq = 1'b0;
        chk("R3 grant next edge", {31'h0, sem_cpu}, 32'h1);
        chk("R3 flag set", {31'h0, evt_acq}, 32'h1);
        pulse(clr_acq);
        chk("R3 flag clear", {31'h0, evt_acq}, 32'h0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule